// File: doc/BRIEF.md
# Boot-Vector Fetch and Indexed-Load Sequencer

This block is a compact fetch-and-execute engine for a small 8-bit instruction subset on a 16-bit address space. When reset is released it reads a two-byte start address from the top two locations of memory. The byte at 0xFFFE becomes the high half of the program counter and the byte at 0xFFFF becomes the low half. It then fetches and runs instructions from that address over a synchronous byte-wide memory port. A read request made in one cycle returns its data on `mem_rdata` in the next cycle.

The subset is the minimum needed for a block-summing loop. It can load or add accumulator A from an indexed address, where the index is either of two 16-bit registers and a 0x18 prefix byte selects the second one. It can load immediate values into the index registers and into accumulator B, decrement B or an index register, and branch while the zero flag is clear. Any byte outside the subset stops the engine and raises a flag that stays set until the next reset. The architectural registers are brought out as ports so that the surrounding logic can observe them.

Top module: `boot_index_seq`

## Requirements
- R1: While `rst_n` is low, `pc`, `acc_a`, `acc_b`, `idx_x` and `idx_y` are zero, `busy` is 1 and `illegal` is 0.
- R2: After reset is released, the engine reads 0xFFFE and then 0xFFFF. The first returned byte becomes `pc[15:8]` and the second becomes `pc[7:0]`. `busy` stays 1 for exactly three cycles, and the first opcode fetch uses the assembled address.
- R3: Each opcode fetch, each 0x18 prefix byte and each operand byte consumed increments `pc` by one, in the cycle in which its read is issued.
- R4: Opcode 0xA6 followed by offset byte k loads A from address X + k. The offset k is zero-extended and the 16-bit sum wraps. A is written on the fourth clock after the opcode fetch starts.
- R5: A 0x18 byte placed before 0xA6, 0xAB, 0xCE or 0x09 makes that instruction use Y instead of X and adds one fetch cycle.
- R6: Opcode 0xAB followed by offset k adds the byte at the indexed address into A, modulo 256, with the same timing as 0xA6.
- R7: Opcode 0xCE followed by two bytes loads X (or Y when prefixed), with the first byte as the high half.
- R8: 0xC6 followed by n loads B with n. 0x5A decrements B, and 0x09 decrements X (or Y when prefixed). Every instruction except 0x01, 0xCE and 0x26 sets the zero flag Z to (result == 0).
- R9: Opcode 0x26 followed by a signed byte r sets `pc` to (address after r) + r when Z is 0, and otherwise falls through. A loop that loads B with COUNT, decrements B and branches back runs its body exactly COUNT times.
- R10: Any other opcode, a prefix in front of an opcode outside the R5 set, or a second prefix sets `illegal`. From then until reset, `illegal` stays 1, no memory read is issued, and `pc` and all registers stay frozen.
- R11: 0x01 changes nothing except `pc`. 0x4F clears A and sets Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | High while the start vector is being fetched |
| illegal | output | 1 | Sticky unsupported-opcode flag |
| pc | output | 16 | Program counter |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B (loop count) |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |

## Verification
The start vector is non-symmetric (0x8A3C), so a design that swapped the two vector bytes would start at the wrong address and diverge at once. An offset of 0xFF on X = 0x1000 and an offset of 0x20 on Y = 0xFFF0 target the sign-extension and wrap cases; a design that sign-extended the offset would read 0x0FFF instead of 0x10FF. Branches are exercised backward while Z is clear, forward over filler, and not taken after B is loaded with zero; an off-by-one in the branch base or in the Z update would change the loop count and the block sum. Prefix misuse (a prefix before 0x5A, and two prefixes in a row) must halt the engine, and a design that ignored the prefix would instead go on to execute the following byte.

// File: rtl/bis_pkg.sv
package bis_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] OPC_PFX   = 8'h18;
  localparam logic [7:0] OPC_LDAIX = 8'hA6;
  localparam logic [7:0] OPC_ADDIX = 8'hAB;
  localparam logic [7:0] OPC_LDIX  = 8'hCE;
  localparam logic [7:0] OPC_DECIX = 8'h09;
  localparam logic [7:0] OPC_NOP   = 8'h01;
  localparam logic [7:0] OPC_CLRA  = 8'h4F;
  localparam logic [7:0] OPC_DECB  = 8'h5A;
  localparam logic [7:0] OPC_LDB   = 8'hC6;
  localparam logic [7:0] OPC_BNE   = 8'h26;

  typedef enum logic [3:0] {
    S_VEC0, S_VEC1, S_VEC2, S_FETCH, S_DEC, S_OP1, S_OP2, S_MEM, S_HALT
  } seq_state_t;

  typedef enum logic [3:0] {
    K_ILL, K_PFX, K_NOP, K_CLRA, K_DECB, K_DECIX,
    K_LDB, K_BNE, K_LDA, K_ADDA, K_LDIX
  } op_kind_t;

endpackage

// File: rtl/bis_decode.sv
module bis_decode
  import bis_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  logic              pfx,
  output op_kind_t          kind
);

  always_comb begin
    unique case (op)
      OPC_PFX:   kind = pfx ? K_ILL : K_PFX;
      OPC_LDAIX: kind = K_LDA;
      OPC_ADDIX: kind = K_ADDA;
      OPC_LDIX:  kind = K_LDIX;
      OPC_DECIX: kind = K_DECIX;
      OPC_NOP:   kind = pfx ? K_ILL : K_NOP;
      OPC_CLRA:  kind = pfx ? K_ILL : K_CLRA;
      OPC_DECB:  kind = pfx ? K_ILL : K_DECB;
      OPC_LDB:   kind = pfx ? K_ILL : K_LDB;
      OPC_BNE:   kind = pfx ? K_ILL : K_BNE;
      default:   kind = K_ILL;
    endcase
  end

endmodule

// File: rtl/bis_agu.sv
module bis_agu #(
  parameter int AW     = 16,
  parameter int OFF_W  = 8,
  parameter bit SIGNED = 1'b0
) (
  input  logic [AW-1:0]    base,
  input  logic [OFF_W-1:0] off,
  output logic [AW-1:0]    sum
);

  localparam int EXT_W = AW - OFF_W;

  logic [AW-1:0] off_ext;

  generate
    if (SIGNED) begin : g_sext
      assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    end else begin : g_zext
      assign off_ext = {{EXT_W{1'b0}}, off};
    end
  endgenerate

  assign sum = base + off_ext;

endmodule

// File: rtl/boot_index_seq.sv
module boot_index_seq
  import bis_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              illegal,
  output logic [AW-1:0]     pc,
  output logic [BYTE_W-1:0] acc_a,
  output logic [BYTE_W-1:0] acc_b,
  output logic [AW-1:0]     idx_x,
  output logic [AW-1:0]     idx_y
);

  localparam logic [AW-1:0] VEC_HI = {{(AW-1){1'b1}}, 1'b0};
  localparam logic [AW-1:0] VEC_LO = {AW{1'b1}};
  localparam logic [AW-1:0] ONE_A  = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [BYTE_W-1:0] ONE_B = {{(BYTE_W-1){1'b0}}, 1'b1};

  seq_state_t st_q, st_d;
  op_kind_t   kind_q, kind_d, dec_kind;
  logic [AW-1:0]     pc_q, pc_d, x_q, x_d, y_q, y_d;
  logic [BYTE_W-1:0] a_q, a_d, b_q, b_d, tmp_q, tmp_d;
  logic              pfx_q, pfx_d, z_q, z_d, ill_q, ill_d;
  logic [AW-1:0]     ix_base, ea, br_tgt;
  logic [BYTE_W-1:0] mem_res;
  logic [AW-1:0]     ix_load;

  bis_decode u_dec (
    .op   (mem_rdata),
    .pfx  (pfx_q),
    .kind (dec_kind)
  );

  assign ix_base = pfx_q ? y_q : x_q;

  bis_agu #(.AW(AW), .OFF_W(BYTE_W), .SIGNED(1'b0)) u_ea (
    .base (ix_base),
    .off  (mem_rdata),
    .sum  (ea)
  );

  bis_agu #(.AW(AW), .OFF_W(BYTE_W), .SIGNED(1'b1)) u_br (
    .base (pc_q),
    .off  (mem_rdata),
    .sum  (br_tgt)
  );

  assign mem_res = (kind_q == K_ADDA) ? (a_q + mem_rdata) : mem_rdata;
  assign ix_load = AW'({tmp_q, mem_rdata});

  // next-state process
  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    pc_d     = pc_q;
    a_d      = a_q;
    b_d      = b_q;
    x_d      = x_q;
    y_d      = y_q;
    tmp_d    = tmp_q;
    pfx_d    = pfx_q;
    z_d      = z_q;
    ill_d    = ill_q;
    mem_rd   = 1'b0;
    mem_addr = pc_q;
    unique case (st_q)
      S_VEC0: begin
        mem_rd   = 1'b1;
        mem_addr = VEC_HI;
        st_d     = S_VEC1;
      end
      S_VEC1: begin
        pc_d     = AW'({mem_rdata, {BYTE_W{1'b0}}});
        mem_rd   = 1'b1;
        mem_addr = VEC_LO;
        st_d     = S_VEC2;
      end
      S_VEC2: begin
        pc_d = {pc_q[AW-1:BYTE_W], mem_rdata};
        st_d = S_FETCH;
      end
      S_FETCH: begin
        mem_rd = 1'b1;
        pc_d   = pc_q + ONE_A;
        pfx_d  = 1'b0;
        st_d   = S_DEC;
      end
      S_DEC: begin
        kind_d = dec_kind;
        unique case (dec_kind)
          K_PFX: begin
            mem_rd = 1'b1;
            pc_d   = pc_q + ONE_A;
            pfx_d  = 1'b1;
          end
          K_NOP: st_d = S_FETCH;
          K_CLRA: begin
            a_d  = '0;
            z_d  = 1'b1;
            st_d = S_FETCH;
          end
          K_DECB: begin
            b_d  = b_q - ONE_B;
            z_d  = (b_q == ONE_B);
            st_d = S_FETCH;
          end
          K_DECIX: begin
            if (pfx_q) begin
              y_d = y_q - ONE_A;
              z_d = (y_q == ONE_A);
            end else begin
              x_d = x_q - ONE_A;
              z_d = (x_q == ONE_A);
            end
            st_d = S_FETCH;
          end
          K_LDB, K_BNE, K_LDA, K_ADDA, K_LDIX: begin
            mem_rd = 1'b1;
            pc_d   = pc_q + ONE_A;
            st_d   = S_OP1;
          end
          default: begin
            ill_d = 1'b1;
            st_d  = S_HALT;
          end
        endcase
      end
      S_OP1: begin
        unique case (kind_q)
          K_LDB: begin
            b_d  = mem_rdata;
            z_d  = (mem_rdata == '0);
            st_d = S_FETCH;
          end
          K_BNE: begin
            if (!z_q) pc_d = br_tgt;
            st_d = S_FETCH;
          end
          K_LDA, K_ADDA: begin
            mem_rd   = 1'b1;
            mem_addr = ea;
            st_d     = S_MEM;
          end
          K_LDIX: begin
            tmp_d  = mem_rdata;
            mem_rd = 1'b1;
            pc_d   = pc_q + ONE_A;
            st_d   = S_OP2;
          end
          default: st_d = S_FETCH;
        endcase
      end
      S_OP2: begin
        if (pfx_q) y_d = ix_load;
        else       x_d = ix_load;
        st_d = S_FETCH;
      end
      S_MEM: begin
        a_d  = mem_res;
        z_d  = (mem_res == '0);
        st_d = S_FETCH;
      end
      S_HALT: st_d = S_HALT;
      default: st_d = S_HALT;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_VEC0;
      kind_q <= K_NOP;
      pc_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      tmp_q  <= '0;
      pfx_q  <= 1'b0;
      z_q    <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      pc_q   <= pc_d;
      a_q    <= a_d;
      b_q    <= b_d;
      x_q    <= x_d;
      y_q    <= y_d;
      tmp_q  <= tmp_d;
      pfx_q  <= pfx_d;
      z_q    <= z_d;
      ill_q  <= ill_d;
    end
  end

  assign busy    = (st_q == S_VEC0) || (st_q == S_VEC1) || (st_q == S_VEC2);
  assign illegal = ill_q;
  assign pc      = pc_q;
  assign acc_a   = a_q;
  assign acc_b   = b_q;
  assign idx_x   = x_q;
  assign idx_y   = y_q;

endmodule

// File: rtl/bis_chk.sv
module bis_chk
  import bis_pkg::*;
#(
  parameter int AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic [AW-1:0]     mem_addr,
  input logic              busy,
  input logic              illegal,
  input logic [AW-1:0]     pc,
  input logic [BYTE_W-1:0] acc_a,
  input logic [BYTE_W-1:0] acc_b,
  input logic [AW-1:0]     idx_x,
  input logic [AW-1:0]     idx_y,
  input seq_state_t        st
);

  // R10
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  // R10
  halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(pc) && $stable(acc_a) && $stable(idx_x) && !mem_rd));

  // R2
  vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rd) |-> (mem_addr[AW-1:1] == {(AW-1){1'b1}}));

  // R2
  busy_noexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(acc_a) && $stable(acc_b) && $stable(idx_x) && $stable(idx_y)));

  // R3
  fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |=> (pc == $past(pc) + 1'b1));

  // R3
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |-> (mem_rd && mem_addr == pc));

endmodule

bind boot_index_seq bis_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .busy     (busy),
  .illegal  (illegal),
  .pc       (pc),
  .acc_a    (acc_a),
  .acc_b    (acc_b),
  .idx_x    (idx_x),
  .idx_y    (idx_y),
  .st       (st_q)
);

// File: tb/boot_index_seq_tb.sv
module boot_index_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        busy, illegal;
  logic [15:0] pc, idx_x, idx_y;
  logic [7:0]  acc_a, acc_b;

  int n_chk = 0;
  int n_fail = 0;

  boot_index_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .illegal(illegal), .pc(pc),
    .acc_a(acc_a), .acc_b(acc_b), .idx_x(idx_x), .idx_y(idx_y)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] mem [int];

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= rd(mem_addr);

  typedef struct packed {
    logic [15:0] pc;
    logic [7:0]  a, b;
    logic [15:0] x, y;
    logic        busy, ill;
  } snap_t;

  snap_t exq[$];
  string tagq[$];
  logic [15:0] m_pc, m_x, m_y;
  logic [7:0]  m_a, m_b;
  logic        m_z, m_busy, m_ill;

  function automatic void push(input string t);
    snap_t e;
    e.pc = m_pc; e.a = m_a; e.b = m_b; e.x = m_x; e.y = m_y;
    e.busy = m_busy; e.ill = m_ill;
    exq.push_back(e);
    tagq.push_back(t);
  endfunction

  function automatic logic [7:0] nxt();
    logic [7:0] v;
    v = rd(m_pc);
    m_pc = m_pc + 16'd1;
    return v;
  endfunction

  task automatic check(input bit ok, input string t, input string got, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %s expected %s", t, got, exp);
    end
  endtask

  // Behavioural reference: expected visible state after every clock edge.
  task automatic model_run();
    logic [7:0] op, v, hi;
    logic       pf;
    m_pc = 0; m_a = 0; m_b = 0; m_x = 0; m_y = 0; m_z = 0; m_busy = 1; m_ill = 0;
    push("R2");
    m_pc = {rd(16'hFFFE), 8'h00};
    push("R2");
    m_pc[7:0] = rd(16'hFFFF);
    m_busy = 0;
    push("R2");
    for (int n = 0; n < 500 && !m_ill; n++) begin
      pf = 0;
      op = nxt(); push("R3");
      if (op == 8'h18) begin
        pf = 1; op = nxt(); push("R5");
        if (op == 8'h18) op = 8'h00;
      end
      if (pf && !(op inside {8'hA6, 8'hAB, 8'hCE, 8'h09})) op = 8'h00;
      case (op)
        8'h01: push("R11");
        8'h4F: begin m_a = 0; m_z = 1; push("R11"); end
        8'h5A: begin m_b = m_b - 1; m_z = (m_b == 0); push("R8"); end
        8'h09: begin
          if (pf) begin m_y = m_y - 1; m_z = (m_y == 0); end
          else    begin m_x = m_x - 1; m_z = (m_x == 0); end
          push("R8");
        end
        8'hC6: begin v = nxt(); push("R3"); m_b = v; m_z = (v == 0); push("R8"); end
        8'h26: begin
          v = nxt(); push("R3");
          if (!m_z) m_pc = m_pc + {{8{v[7]}}, v};
          push("R9");
        end
        8'hA6, 8'hAB: begin
          v = nxt(); push("R3"); push("R4");
          v = rd((pf ? m_y : m_x) + {8'h00, v});
          m_a = (op == 8'hAB) ? m_a + v : v;
          m_z = (m_a == 0);
          push(op == 8'hAB ? "R6" : "R4");
        end
        8'hCE: begin
          hi = nxt(); push("R3");
          v = nxt(); push("R7");
          if (pf) m_y = {hi, v}; else m_x = {hi, v};
          push("R7");
        end
        default: begin m_ill = 1; push("R10"); end
      endcase
    end
    repeat (4) push("R10");
  endtask

  task automatic run_case();
    snap_t e, g;
    string t;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(pc == 0 && acc_a == 0 && acc_b == 0 && idx_x == 0 && idx_y == 0 && busy && !illegal,
          "R1", $sformatf("pc=%h a=%h b=%h x=%h y=%h busy=%b ill=%b", pc, acc_a, acc_b, idx_x, idx_y, busy, illegal),
          "all zero, busy=1, ill=0");
    model_run();
    rst_n = 1'b1;
    while (exq.size() > 0) begin
      @(negedge clk);
      e = exq.pop_front();
      t = tagq.pop_front();
      g.pc = pc; g.a = acc_a; g.b = acc_b; g.x = idx_x; g.y = idx_y;
      g.busy = busy; g.ill = illegal;
      check(g == e, t,
            $sformatf("pc=%h a=%h b=%h x=%h y=%h busy=%b ill=%b", g.pc, g.a, g.b, g.x, g.y, g.busy, g.ill),
            $sformatf("pc=%h a=%h b=%h x=%h y=%h busy=%b ill=%b", e.pc, e.a, e.b, e.x, e.y, e.busy, e.ill));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] sum;
    rst_n = 1'b0;
    // Case A: block-sum loop, start 0x2000 (R9, R6, R8, R7, R11)
    mem.delete();
    mem[16'hFFFE] = 8'h20; mem[16'hFFFF] = 8'h00;
    mem[16'h2000] = 8'h4F;
    mem[16'h2001] = 8'hCE; mem[16'h2002] = 8'h20; mem[16'h2003] = 8'h67;
    mem[16'h2004] = 8'hC6; mem[16'h2005] = 8'h07;
    mem[16'h2006] = 8'hAB; mem[16'h2007] = 8'h00;
    mem[16'h2008] = 8'h09; mem[16'h2009] = 8'h5A;
    mem[16'h200A] = 8'h26; mem[16'h200B] = 8'hFA;
    sum = 0;
    for (int i = 0; i < 7; i++) begin
      mem[16'h2061 + i] = 8'h11 * (i + 1);
      sum = sum + 8'(8'h11 * (i + 1));
    end
    run_case();
    check(acc_a == sum, "R9", $sformatf("%h", acc_a), $sformatf("%h", sum));
    check(acc_b == 8'h00, "R9", $sformatf("%h", acc_b), "00");
    check(idx_x == 16'h2060, "R8", $sformatf("%h", idx_x), "2060");

    // Case B: swapped-looking vector, Y prefix, offset wrap, branches (R4, R5, R9, R10)
    mem.delete();
    mem[16'hFFFE] = 8'h8A; mem[16'hFFFF] = 8'h3C;
    mem[16'h0010] = 8'h3C; mem[16'h10FF] = 8'hA5; mem[16'h0FFF] = 8'hEE;
    begin
      logic [7:0] prog [24] = '{8'h18, 8'hCE, 8'hFF, 8'hF0, 8'h18, 8'hA6, 8'h20,
                                 8'hCE, 8'h10, 8'h00, 8'hA6, 8'hFF, 8'h18, 8'h09,
                                 8'h01, 8'h5A, 8'h26, 8'h02, 8'h00, 8'h00,
                                 8'hC6, 8'h00, 8'h26, 8'hF0};
      for (int i = 0; i < 24; i++) mem[16'h8A3C + i] = prog[i];
      mem[16'h8A3C + 24] = 8'h18; mem[16'h8A3C + 25] = 8'h18;
    end
    run_case();
    check(acc_a == 8'hA5, "R4", $sformatf("%h", acc_a), "a5");
    check(idx_y == 16'hFFEF, "R5", $sformatf("%h", idx_y), "ffef");
    check(illegal == 1'b1, "R10", $sformatf("%b", illegal), "1");

    // Case C: prefix before an opcode outside the Y set (R10)
    mem.delete();
    mem[16'hFFFE] = 8'h40; mem[16'hFFFF] = 8'h00;
    mem[16'h4000] = 8'h18; mem[16'h4001] = 8'h5A;
    run_case();
    check(acc_b == 8'h00 && pc == 16'h4002, "R10",
          $sformatf("b=%h pc=%h", acc_b, pc), "b=00 pc=4002");

    // Case D: start at zero, add through X = 0 (R6, R11)
    mem.delete();
    mem[16'h0000] = 8'h01; mem[16'h0001] = 8'h01;
    mem[16'h0002] = 8'hAB; mem[16'h0003] = 8'h01;
    mem[16'h0004] = 8'hAB; mem[16'h0005] = 8'h02;
    mem[16'h0006] = 8'h77;
    run_case();
    check(acc_a == 8'hAC, "R6", $sformatf("%h", acc_a), "ac");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule